// File: doc/BRIEF.md
# Differential Quadrature Phase Symbol Mapper

This block converts a serial bit stream into quantized in-phase and quadrature amplitudes for a differentially encoded four-phase modulator whose carrier phase moves in steps of pi/4. Each accepted bit is marked by a valid strobe. Bits are collected two at a time. Each completed pair selects a phase change, not an absolute constellation point. That change is added to a running phase held on an eight-point circle. As a result, the transmitted points alternate between the axis set and the diagonal set.

For every completed pair the block presents new signed I and Q values for the updated phase and raises a one-cycle symbol strobe. The outputs hold their values between symbols. The block feeds a pulse shaping stage and has no analog or filtering function of its own.

Top module: `dqpsk_mapper`

## Requirements
- R1: While the synchronous active-high reset is applied, the phase index becomes 0, the outputs become I = +FULL_SCALE and Q = 0, and the symbol strobe is low.
- R2: A bit is taken only in a cycle where the valid input is high. The first bit taken of a pair is A and the second is B. Bit values presented while valid is low have no effect.
- R3: The phase index is 3 bits wide, in units of pi/4, and wraps modulo 8. A pair advances it by +1 when AB = 00, by +3 when AB = 10, by +5 when AB = 11 and by +7 when AB = 01.
- R4: Phase index k maps to the following (I, Q) values: 0 → (+F, 0), 1 → (+D, +D), 2 → (0, +F), 3 → (−D, +D), 4 → (−F, 0), 5 → (−D, −D), 6 → (0, −F), 7 → (+D, −D). Here F = FULL_SCALE (default 127) and D = DIAG_SCALE (default 90).
- R5: The symbol strobe is high for exactly one cycle, in the cycle after the second bit of a pair is presented. I and Q take their new values in that same cycle.
- R6: A lone first bit is held for any number of idle cycles until its partner arrives, and produces no strobe. I and Q keep their values in every cycle without a strobe.
- R7: Starting from reset, the pairs 00, 11, 11, 01 give phase indices 1, 6, 3, 2, that is, outputs (+D,+D), (0,−F), (−D,+D), (0,+F).
- R8: A reset applied while a first bit is pending discards that bit, so the next two accepted bits form a fresh pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Serial bit qualifier |
| bit_in | input | 1 | Serial data bit |
| sym_stb | output | 1 | One-cycle strobe marking a new symbol |
| i_amp | output | AMP_W | Signed in-phase amplitude |
| q_amp | output | AMP_W | Signed quadrature amplitude |

## Verification
The four-pair example sequence checks the step table against fixed known phases. A long run of each single pair value walks the phase around the full circle, which exercises the modulo-8 wrap and every table entry for every step size. A sequence with lone bits split by idle cycles, with the data line toggling while valid is low, separates correct pairing from pairing on the raw data line. A reset applied with a half pair pending shows whether that stale bit is discarded, and long randomized streams with gaps and back-to-back valid bits check the timing of the strobe.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;
  localparam int PH_W  = 3;
  localparam int N_PTS = 1 << PH_W;

  typedef logic [PH_W-1:0] phase_t;

  typedef struct packed {
    logic a;
    logic b;
  } dibit_t;

  // phase advance in units of pi/4 for a completed pair
  function automatic phase_t step_of(dibit_t d);
    case ({d.a, d.b})
      2'b00:   return phase_t'(1);
      2'b10:   return phase_t'(3);
      2'b11:   return phase_t'(5);
      default: return phase_t'(7);
    endcase
  endfunction

  // quadrant sign / magnitude selection for index k: returns {i_sel, q_sel}
  // sel: 0 -> zero, 1 -> +full, 2 -> -full, 3 -> +diag, 4 -> -diag
  function automatic logic [5:0] point_sel(int k);
    case (k % N_PTS)
      0:       return {3'd1, 3'd0};
      1:       return {3'd3, 3'd3};
      2:       return {3'd0, 3'd1};
      3:       return {3'd4, 3'd3};
      4:       return {3'd2, 3'd0};
      5:       return {3'd4, 3'd4};
      6:       return {3'd0, 3'd2};
      default: return {3'd3, 3'd4};
    endcase
  endfunction
endpackage

// File: rtl/dq_bit_pairer.sv
module dq_bit_pairer
  import dqpsk_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_vld,
  input  logic   bit_in,
  output logic   pair_vld,
  output dibit_t pair
);
  logic have_a;
  logic a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_a <= 1'b0;
      a_q    <= 1'b0;
    end else if (bit_vld) begin
      have_a <= ~have_a;
      if (!have_a) a_q <= bit_in;
    end
  end

  assign pair_vld = bit_vld & have_a;
  assign pair.a   = a_q;
  assign pair.b   = bit_in;
endmodule

// File: rtl/dq_phase_acc.sv
module dq_phase_acc
  import dqpsk_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pair_vld,
  input  dibit_t pair,
  output phase_t phase_nxt,
  output phase_t phase_q
);
  assign phase_nxt = pair_vld ? phase_t'(phase_q + step_of(pair)) : phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_nxt;
  end
endmodule

// File: rtl/dq_iq_rom.sv
module dq_iq_rom
  import dqpsk_pkg::*;
#(
  parameter int AMP_W      = 8,
  parameter int FULL_SCALE = 127,
  parameter int DIAG_SCALE = 90
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  phase_t                  rd_idx,
  output logic signed [AMP_W-1:0] i_out,
  output logic signed [AMP_W-1:0] q_out
);
  localparam int WORD_W = 2 * AMP_W;
  localparam logic signed [AMP_W-1:0] P_FULL = AMP_W'(FULL_SCALE);
  localparam logic signed [AMP_W-1:0] P_DIAG = AMP_W'(DIAG_SCALE);

  function automatic logic signed [AMP_W-1:0] amp_of(logic [2:0] sel);
    case (sel)
      3'd1:    return P_FULL;
      3'd2:    return -P_FULL;
      3'd3:    return P_DIAG;
      3'd4:    return -P_DIAG;
      default: return '0;
    endcase
  endfunction

  logic [WORD_W-1:0] rom [N_PTS];

  for (genvar k = 0; k < N_PTS; k++) begin : g_pt
    localparam logic [5:0] SEL = point_sel(k);
    assign rom[k] = {amp_of(SEL[5:3]), amp_of(SEL[2:0])};
  end

  // registered read, reset to the phase-0 point
  always_ff @(posedge clk) begin
    if (rst) begin
      i_out <= P_FULL;
      q_out <= '0;
    end else if (rd_en) begin
      i_out <= rom[rd_idx][WORD_W-1:AMP_W];
      q_out <= rom[rd_idx][AMP_W-1:0];
    end
  end
endmodule

// File: rtl/dqpsk_mapper.sv
module dqpsk_mapper
  import dqpsk_pkg::*;
#(
  parameter int AMP_W      = 8,
  parameter int FULL_SCALE = 127,
  parameter int DIAG_SCALE = 90
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_vld,
  input  logic                    bit_in,
  output logic                    sym_stb,
  output logic signed [AMP_W-1:0] i_amp,
  output logic signed [AMP_W-1:0] q_amp
);
  logic   pair_vld;
  dibit_t pair;
  phase_t phase_nxt;
  phase_t phase_q;

  dq_bit_pairer u_pair (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .pair_vld (pair_vld),
    .pair     (pair)
  );

  dq_phase_acc u_acc (
    .clk       (clk),
    .rst       (rst),
    .pair_vld  (pair_vld),
    .pair      (pair),
    .phase_nxt (phase_nxt),
    .phase_q   (phase_q)
  );

  dq_iq_rom #(
    .AMP_W      (AMP_W),
    .FULL_SCALE (FULL_SCALE),
    .DIAG_SCALE (DIAG_SCALE)
  ) u_rom (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (pair_vld),
    .rd_idx (phase_nxt),
    .i_out  (i_amp),
    .q_out  (q_amp)
  );

  always_ff @(posedge clk) begin
    if (rst) sym_stb <= 1'b0;
    else     sym_stb <= pair_vld;
  end
endmodule

// File: rtl/dqpsk_mapper_chk.sv
module dqpsk_mapper_chk #(
  parameter int AMP_W      = 8,
  parameter int FULL_SCALE = 127,
  parameter int DIAG_SCALE = 90
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bit_vld,
  input logic                    sym_stb,
  input logic signed [AMP_W-1:0] i_amp,
  input logic signed [AMP_W-1:0] q_amp
);
  localparam logic signed [AMP_W-1:0] C_F = AMP_W'(FULL_SCALE);
  localparam logic signed [AMP_W-1:0] C_D = AMP_W'(DIAG_SCALE);

  logic on_axis, on_diag, is_diag;
  assign on_axis = (i_amp == 0 && (q_amp == C_F || q_amp == -C_F)) ||
                   (q_amp == 0 && (i_amp == C_F || i_amp == -C_F));
  assign on_diag = (i_amp == C_D || i_amp == -C_D) && (q_amp == C_D || q_amp == -C_D);
  assign is_diag = (i_amp != 0) && (q_amp != 0);

  logic started;
  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  // R1: reset state
  assert_reset_point_R1: assert property (@(posedge clk)
    rst |=> (!sym_stb && i_amp == C_F && q_amp == 0));

  // R4: outputs always sit on one of the eight points
  assert_on_circle_R4: assert property (@(posedge clk) disable iff (rst)
    started |-> (on_axis || on_diag));

  // R5: strobe lasts one cycle
  assert_stb_single_R5: assert property (@(posedge clk) disable iff (rst)
    sym_stb |=> !sym_stb);

  // R5: strobe only follows an accepted bit
  assert_stb_after_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (started && sym_stb) |-> $past(bit_vld));

  // R6: outputs hold between symbols
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (started && !sym_stb) |-> ($stable(i_amp) && $stable(q_amp)));

  // R3: every step is an odd multiple of pi/4, so the point set alternates
  assert_odd_step_R3: assert property (@(posedge clk) disable iff (rst)
    (started && sym_stb) |-> (is_diag != $past(is_diag)));
endmodule

bind dqpsk_mapper dqpsk_mapper_chk #(
  .AMP_W      (AMP_W),
  .FULL_SCALE (FULL_SCALE),
  .DIAG_SCALE (DIAG_SCALE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_vld (bit_vld),
  .sym_stb (sym_stb),
  .i_amp   (i_amp),
  .q_amp   (q_amp)
);

// File: tb/test_dqpsk_mapper.sv
module test_dqpsk_mapper;
  localparam int AMP_W = 8;
  localparam int F = 127;
  localparam int D = 90;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic sym_stb;
  logic signed [AMP_W-1:0] i_amp;
  logic signed [AMP_W-1:0] q_amp;

  dqpsk_mapper #(.AMP_W(AMP_W), .FULL_SCALE(F), .DIAG_SCALE(D)) i_dqpsk_mapper (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .sym_stb(sym_stb), .i_amp(i_amp), .q_amp(q_amp)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  string req = "R1";

  // behavioural model
  int  m_phase = 0;
  bit  m_have = 0;
  bit  m_a = 0;
  int  e_i = F, e_q = 0;
  bit  e_stb = 0;

  function automatic int cos_of(int k);
    int t[8] = '{F, D, 0, -D, -F, -D, 0, D};
    return t[k % 8];
  endfunction

  function automatic int sin_of(int k);
    int t[8] = '{0, D, F, D, 0, -D, -F, -D};
    return t[k % 8];
  endfunction

  function automatic int inc_of(bit a, bit b);
    if (!a && !b) return 1;
    if (a && !b)  return 3;
    if (a && b)   return 5;
    return 7;
  endfunction

  task automatic compare();
    n_cmp++;
    if (sym_stb !== e_stb || int'(i_amp) != e_i || int'(q_amp) != e_q) begin
      n_bad++;
      $display("FAIL %s: got stb=%0b I=%0d Q=%0d, expected stb=%0b I=%0d Q=%0d",
               req, sym_stb, i_amp, q_amp, e_stb, e_i, e_q);
    end
  endtask

  // compare current outputs, then drive one cycle and advance the model
  task automatic step(bit r, bit v, bit b);
    @(negedge clk);
    compare();
    rst = r; bit_vld = v; bit_in = b;
    e_stb = 0;
    if (r) begin
      m_phase = 0; m_have = 0; m_a = 0; e_i = F; e_q = 0;
    end else if (v) begin
      if (m_have) begin
        m_phase = (m_phase + inc_of(m_a, b)) % 8;
        e_i = cos_of(m_phase); e_q = sin_of(m_phase);
        e_stb = 1; m_have = 0;
      end else begin
        m_a = b; m_have = 1;
      end
    end
  endtask

  task automatic pair(bit a, bit b);
    step(0, 1, a);
    step(0, 1, b);
  endtask

  bit done = 0;

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    req = "R1";
    step(1, 0, 0);
    step(1, 0, 1);
    step(0, 0, 0);
    step(0, 0, 1);

    // R7: example sequence 00 11 11 01 -> phases 1,6,3,2
    req = "R7";
    pair(0, 0); pair(1, 1); pair(1, 1); pair(0, 1);
    step(0, 0, 0);
    n_cmp++;
    if (int'(i_amp) != 0 || int'(q_amp) != F) begin
      n_bad++;
      $display("FAIL R7: got I=%0d Q=%0d, expected I=0 Q=%0d", i_amp, q_amp, F);
    end

    // R3/R4: each pair value repeated around the full circle
    req = "R3";
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 9; n++) pair(p[1], p[0]);
    req = "R4";
    for (int n = 0; n < 8; n++) begin pair(0, 0); step(0, 0, 0); end

    // R2/R6: lone bits held over gaps while the data line toggles
    req = "R6";
    step(0, 1, 1);
    for (int n = 0; n < 6; n++) step(0, 0, n[0]);
    step(0, 1, 0);
    step(0, 0, 1);
    req = "R2";
    step(0, 1, 0);
    for (int n = 0; n < 4; n++) step(0, 0, 1);
    step(0, 1, 1);
    for (int n = 0; n < 3; n++) step(0, 0, 0);

    // R8: reset with a pending first bit
    req = "R8";
    pair(1, 0);
    step(0, 1, 1);
    step(1, 0, 0);
    step(0, 0, 0);
    pair(0, 0);
    step(0, 0, 0);
    step(0, 1, 1); step(0, 0, 0); step(1, 1, 0); step(0, 1, 1); step(0, 1, 0);
    step(0, 0, 0);

    // R5: back-to-back bits, then randomized gaps
    req = "R5";
    for (int n = 0; n < 400; n++) step(0, 1, 1'($urandom));
    req = "R4";
    for (int n = 0; n < 3000; n++) step(0, 1'(($urandom % 3) != 0), 1'($urandom));
    step(0, 0, 0);
    step(0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule